// File: doc/BRIEF.md
# Skip-Symbol Rate Matcher

This block is an elastic buffer that carries 10-bit code groups from a recovered receive clock to a local read clock. The two clocks run near the same rate but are not locked, so the buffer slowly fills or drains. To absorb the drift it watches the stream for a two-symbol marker: a control group immediately followed by a skip group. When the buffer is close to full and the write side sees a marker, the skip group is discarded. When the buffer is close to empty and the read side emits a marker, the skip group is output a second time. The control group itself always passes through.

Two markers are configured, one for each running-disparity polarity, and a marker is recognised only when its control and skip groups come from the same pair. Because a skip group has as many ones as zeros, adding or dropping one leaves the stream's running disparity unchanged. Four status outputs report the buffer state: a full level and a deleted pulse in the write domain, and an empty level and an inserted pulse in the read domain. Two sticky error flags record a write into a full buffer or a read from an empty one.

Top module: `skip_rate_matcher`

## Requirements
- R1: Code groups that are not removed leave `rd_data` in the order they entered on `wr_data`, one per `rd_en` cycle, with `rd_valid` high the cycle after the read.
- R2: Each marker parameter is 20 bits wide: bits 9:0 hold the control group and bits 19:10 the skip group. Markers from `PAT_POS` and from `PAT_NEG` are both recognised.
- R3: When a skip group completes a marker on the write side and the stored count is at or above `HI_MARK`, that skip group is not stored and the control group before it is kept.
- R4: A marker seen on the write side while the stored count is below `HI_MARK` is stored unchanged.
- R5: When the read side outputs a marker's skip group and the stored count before that read is at or below `LO_MARK`, the next `rd_en` cycle outputs the same skip group again without consuming a stored entry.
- R6: A marker read while the stored count before the skip read is above `LO_MARK` is not repeated.
- R7: `deleted` is a one-cycle pulse in the `wclk` domain for each removed skip group; `inserted` is a one-cycle pulse in the `rclk` domain for each repeated skip group.
- R8: `full` is high while 2**`AW` groups are stored; a group offered while full and not removed is dropped and sets `wr_ovf_err`, which stays high until reset.
- R9: `empty` is high while nothing is stored; `rd_en` with nothing stored and no repeat pending leaves `rd_valid` low and sets `rd_unf_err`, which stays high until reset.
- R10: Each marker causes at most one removal or repetition: a second skip group after a removed one is stored, and a control group from one pair followed by a skip group from the other is not a marker.
- R11: After reset `full`, `deleted`, `inserted`, `rd_valid` and both error flags are low and `empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write (recovered) clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_valid | input | 1 | A code group is present on `wr_data` |
| wr_data | input | 10 | Incoming code group |
| full | output | 1 | Buffer holds 2**AW groups (write domain level) |
| deleted | output | 1 | One-cycle pulse: a skip group was removed |
| wr_ovf_err | output | 1 | Sticky: a group was dropped because the buffer was full |
| rclk | input | 1 | Read (local) clock |
| rrst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_en | input | 1 | Request one code group |
| rd_valid | output | 1 | `rd_data` holds a group produced by the last request |
| rd_data | output | 10 | Outgoing code group |
| empty | output | 1 | Nothing stored (read domain level) |
| inserted | output | 1 | One-cycle pulse: a skip group was repeated |
| rd_unf_err | output | 1 | Sticky: a request found nothing to output |

## Verification
A wrong fill count, whether from a bad pointer, a bad Gray conversion or a broken synchronizer, moves the point where removal or repetition sets in. The bench sweeps the marker's position across every fill level, so an off-by-one count produces a wrong `deleted` or `inserted` total and a stream one group too long or too short, both visible when the case is read back. A stale marker-tracking flag causes a repetition or removal that should not happen, or misses one, and the mixed-pair and double-skip cases expose this within the same pass. Pointer wrap errors show up as a reordered or repeated `rd_data` sequence, or as `full` or `empty` at the wrong count.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int SYM_W = 10;
  typedef logic [SYM_W-1:0] sym_t;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // occupancy between two PW-bit pointers held in 32-bit words
  function automatic int unsigned ptr_fill(logic [31:0] wp, logic [31:0] rp, int unsigned pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (wp - rp) & mask;
  endfunction
endpackage

// File: rtl/rm_sync.sv
module rm_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rm_pair_det.sv
module rm_pair_det
  import rm_pkg::*;
#(
  parameter logic [2*SYM_W-1:0] PAT_A = '0,
  parameter logic [2*SYM_W-1:0] PAT_B = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  sym_t sym,
  output logic hit
);
  localparam sym_t A_CTL = PAT_A[SYM_W-1:0];
  localparam sym_t A_SKP = PAT_A[2*SYM_W-1:SYM_W];
  localparam sym_t B_CTL = PAT_B[SYM_W-1:0];
  localparam sym_t B_SKP = PAT_B[2*SYM_W-1:SYM_W];

  logic after_a, after_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      after_a <= 1'b0;
      after_b <= 1'b0;
    end else if (adv) begin
      after_a <= (sym == A_CTL);
      after_b <= (sym == B_CTL);
    end
  end

  assign hit = adv && ((after_a && sym == A_SKP) || (after_b && sym == B_SKP));
endmodule

// File: rtl/skip_rate_matcher.sv
module skip_rate_matcher
  import rm_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned HI_MARK = 12,
  parameter int unsigned LO_MARK = 3,
  parameter logic [2*SYM_W-1:0] PAT_POS = 20'hAD0FA,
  parameter logic [2*SYM_W-1:0] PAT_NEG = 20'h52E83
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_valid,
  input  logic [SYM_W-1:0] wr_data,
  output logic             full,
  output logic             deleted,
  output logic             wr_ovf_err,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [SYM_W-1:0] rd_data,
  output logic             empty,
  output logic             inserted,
  output logic             rd_unf_err
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW = AW + 1;

  sym_t mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_gray_w;
  int unsigned   wfill;
  logic          w_pair, del_now, do_write, ovf_now;

  rm_sync #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rptr_gray), .q(rptr_gray_w)
  );

  rm_pair_det #(.PAT_A(PAT_POS), .PAT_B(PAT_NEG)) u_det_w (
    .clk(wclk), .rst_n(wrst_n), .adv(wr_valid), .sym(wr_data), .hit(w_pair)
  );

  assign wfill    = ptr_fill(32'(wptr_bin), gray2bin(32'(rptr_gray_w)), PW);
  assign full     = (wfill == DEPTH);
  assign del_now  = w_pair && (wfill >= HI_MARK);
  assign do_write = wr_valid && !del_now && !full;
  assign ovf_now  = wr_valid && !del_now && full;

  always_ff @(posedge wclk) begin
    if (do_write) mem[wptr_bin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr_bin   <= '0;
      wptr_gray  <= '0;
      deleted    <= 1'b0;
      wr_ovf_err <= 1'b0;
    end else begin
      if (do_write) begin
        wptr_bin  <= wptr_bin + 1'b1;
        wptr_gray <= PW'(bin2gray(32'(wptr_bin + 1'b1)));
      end
      deleted <= del_now;
      if (ovf_now) wr_ovf_err <= 1'b1;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rptr_bin, rptr_gray, wptr_gray_r;
  int unsigned   rfill;
  sym_t          rd_sym;
  logic          r_pair, pop, rep, ins_arm, ins_pend, unf_now;

  rm_sync #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wptr_gray), .q(wptr_gray_r)
  );

  rm_pair_det #(.PAT_A(PAT_POS), .PAT_B(PAT_NEG)) u_det_r (
    .clk(rclk), .rst_n(rrst_n), .adv(pop), .sym(rd_sym), .hit(r_pair)
  );

  assign rfill   = ptr_fill(gray2bin(32'(wptr_gray_r)), 32'(rptr_bin), PW);
  assign empty   = (rfill == 0);
  assign rd_sym  = mem[rptr_bin[AW-1:0]];
  assign pop     = rd_en && !ins_pend && !empty;
  assign rep     = rd_en && ins_pend;
  assign ins_arm = r_pair && (rfill <= LO_MARK);
  assign unf_now = rd_en && !ins_pend && empty;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr_bin   <= '0;
      rptr_gray  <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      inserted   <= 1'b0;
      ins_pend   <= 1'b0;
      rd_unf_err <= 1'b0;
    end else begin
      if (pop) begin
        rd_data   <= rd_sym;
        rptr_bin  <= rptr_bin + 1'b1;
        rptr_gray <= PW'(bin2gray(32'(rptr_bin + 1'b1)));
      end
      rd_valid <= pop || rep;
      inserted <= rep;
      if (ins_arm)  ins_pend <= 1'b1;
      else if (rep) ins_pend <= 1'b0;
      if (unf_now) rd_unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/skip_rate_matcher_chk.sv
module skip_rate_matcher_chk #(
  parameter int unsigned AW = 4
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          deleted,
  input logic          inserted,
  input logic          wr_ovf_err,
  input logic          rd_unf_err,
  input logic          rd_valid,
  input logic [9:0]    rd_data,
  input logic [AW:0]   wptr_bin,
  input logic [AW:0]   rptr_bin,
  input int unsigned   wfill
);
  localparam int unsigned DEPTH = 1 << AW;

  p_del_pulse_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    deleted |=> !deleted);

  p_del_hold_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    deleted |-> wptr_bin == $past(wptr_bin));

  p_no_overflow_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    wfill <= DEPTH);

  p_ovf_sticky_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_ovf_err |=> wr_ovf_err);

  p_ins_pulse_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    inserted |=> !inserted);

  p_ins_hold_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    inserted |-> rd_valid && rptr_bin == $past(rptr_bin) && rd_data == $past(rd_data));

  p_unf_sticky_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_unf_err |=> rd_unf_err);

  p_unf_novalid_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(rd_unf_err) |-> !rd_valid);
endmodule

bind skip_rate_matcher skip_rate_matcher_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .deleted(deleted), .inserted(inserted),
  .wr_ovf_err(wr_ovf_err), .rd_unf_err(rd_unf_err),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .wptr_bin(wptr_bin), .rptr_bin(rptr_bin), .wfill(wfill)
);

// File: tb/tb_skip_rate_matcher.sv
module tb_skip_rate_matcher;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HI = 12;
  localparam int LO = 3;
  localparam int DEP = 16;
  localparam logic [9:0] PC = 10'h0FA, PS = 10'h2B4;  // positive pair
  localparam logic [9:0] NC = 10'h283, NS = 10'h14B;  // negative pair

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_valid = 0, rd_en = 0;
  logic [9:0] wr_data = '0;
  logic full, deleted, wr_ovf_err, rd_valid, empty, inserted, rd_unf_err;
  logic [9:0] rd_data;

  always #2.5 wclk = ~wclk;
  always #2.7 rclk = ~rclk;

  skip_rate_matcher #(
    .AW(4), .HI_MARK(HI), .LO_MARK(LO),
    .PAT_POS({PS, PC}), .PAT_NEG({NS, NC})
  ) dut (
    .wclk(wclk), .wrst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .full(full), .deleted(deleted), .wr_ovf_err(wr_ovf_err),
    .rclk(rclk), .rrst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .empty(empty), .inserted(inserted), .rd_unf_err(rd_unf_err)
  );

  int n_run = 0, n_fail = 0;
  int del_cnt, ins_cnt;
  logic [9:0] stim[$], expq[$], got[$];

  always @(negedge wclk) if (!rst_n) del_cnt <= 0; else if (deleted) del_cnt <= del_cnt + 1;
  always @(negedge rclk) if (!rst_n) ins_cnt <= 0; else if (inserted) ins_cnt <= ins_cnt + 1;

  function automatic logic [9:0] dsym(int i);
    return 10'h100 + 10'(i);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_valid = 0; rd_en = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic send_one(input logic [9:0] s);
    @(negedge wclk); wr_valid = 1; wr_data = s;
    @(negedge wclk); wr_valid = 0;
  endtask

  task automatic send_all();
    foreach (stim[i]) begin
      @(negedge wclk); wr_valid = 1; wr_data = stim[i];
    end
    @(negedge wclk); wr_valid = 0;
    repeat (8) @(negedge rclk);
  endtask

  task automatic recv(input int n);
    got.delete();
    @(negedge rclk); rd_en = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      if (i == n - 1) rd_en = 0;
      if (rd_valid) got.push_back(rd_data);
    end
  endtask

  task automatic cmp_seq(input string tag);
    int bad;
    bad = -1;
    chk(got.size() == expq.size(), {tag, " length"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      if (bad < 0 && got[i] != expq[i]) bad = i;
    if (bad >= 0) chk(0, {tag, " content"}, got[bad], expq[bad]);
    else chk(1, {tag, " content"}, 0, 0);
  endtask

  task automatic run_case(input string tag, input int e_del, input int e_ins);
    do_reset();
    send_all();
    recv(expq.size());
    repeat (2) @(negedge wclk);
    chk(del_cnt == e_del, {tag, " R3/R4/R7 deleted count"}, del_cnt, e_del);
    chk(ins_cnt == e_ins, {tag, " R5/R6/R7 inserted count"}, ins_cnt, e_ins);
    cmp_seq({tag, " R1 stream"});
    chk(!wr_ovf_err && !rd_unf_err, {tag, " no error flags"}, {wr_ovf_err, rd_unf_err}, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset();
    chk(!full && !deleted && !inserted && !rd_valid, "R11 levels after reset", {full, deleted, inserted, rd_valid}, 0);
    chk(empty, "R11 empty after reset", empty, 1);
    chk(!wr_ovf_err && !rd_unf_err, "R11 error flags after reset", {wr_ovf_err, rd_unf_err}, 0);

    // R3/R4 sweep: marker at every write fill level; remaining read fill is 1 so
    // a stored marker is always repeated (R5)
    for (int k = 0; k <= 14; k++) begin
      int dl;
      stim.delete(); expq.delete();
      for (int i = 0; i < k; i++) begin stim.push_back(dsym(i)); expq.push_back(dsym(i)); end
      stim.push_back(PC); stim.push_back(PS);
      expq.push_back(PC);
      dl = (k + 1 >= HI) ? 1 : 0;
      if (dl == 0) begin expq.push_back(PS); expq.push_back(PS); end
      run_case($sformatf("del sweep k=%0d", k), dl, 1 - dl);
    end

    // R5/R6 sweep: ten groups, marker at position p; fill before skip read is 10-p-1
    for (int p = 0; p <= 8; p++) begin
      int il;
      stim.delete(); expq.delete();
      il = (10 - p - 1 <= LO) ? 1 : 0;
      for (int i = 0; i < 10; i++) begin
        logic [9:0] s;
        s = (i == p) ? PC : (i == p + 1) ? PS : dsym(i);
        stim.push_back(s); expq.push_back(s);
        if (i == p + 1 && il == 1) expq.push_back(PS);
      end
      run_case($sformatf("ins sweep p=%0d", p), 0, il);
    end

    // R2 negative pair removed at high fill
    stim.delete(); expq.delete();
    for (int i = 0; i < 11; i++) begin stim.push_back(dsym(i)); expq.push_back(dsym(i)); end
    stim.push_back(NC); stim.push_back(NS); expq.push_back(NC);
    run_case("R2 negative pair delete", 1, 0);

    // R2 negative pair repeated at low fill
    stim.delete(); expq.delete();
    for (int i = 0; i < 4; i++) begin stim.push_back(dsym(i)); expq.push_back(dsym(i)); end
    stim.push_back(NC); stim.push_back(NS); stim.push_back(dsym(9));
    expq.push_back(NC); expq.push_back(NS); expq.push_back(NS); expq.push_back(dsym(9));
    run_case("R2 negative pair insert", 0, 1);

    // R10 mixed pair is not a marker
    stim.delete(); expq.delete();
    for (int i = 0; i < 11; i++) begin stim.push_back(dsym(i)); expq.push_back(dsym(i)); end
    stim.push_back(PC); stim.push_back(NS); expq.push_back(PC); expq.push_back(NS);
    run_case("R10 mixed pair", 0, 0);

    // R10 double skip: only the first is removed; the stored one is then repeated
    stim.delete(); expq.delete();
    for (int i = 0; i < 11; i++) begin stim.push_back(dsym(i)); expq.push_back(dsym(i)); end
    stim.push_back(PC); stim.push_back(PS); stim.push_back(PS);
    expq.push_back(PC); expq.push_back(PS); expq.push_back(PS);
    run_case("R10 double skip", 1, 1);

    // R8 full and overflow, R9 empty and underflow
    do_reset();
    stim.delete(); expq.delete();
    for (int i = 0; i < DEP; i++) begin stim.push_back(dsym(i)); expq.push_back(dsym(i)); end
    send_all();
    @(negedge wclk);
    chk(full, "R8 full at 16 stored", full, 1);
    chk(!wr_ovf_err, "R8 no overflow yet", wr_ovf_err, 0);
    send_one(dsym(20));
    chk(wr_ovf_err, "R8 overflow flag set", wr_ovf_err, 1);
    repeat (8) @(negedge rclk);
    recv(DEP);
    cmp_seq("R8 dropped group absent");
    chk(empty, "R9 empty after draining", empty, 1);
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    chk(!rd_valid, "R9 no valid on empty read", rd_valid, 0);
    chk(rd_unf_err, "R9 underflow flag set", rd_unf_err, 1);
    repeat (3) @(negedge rclk);
    chk(rd_unf_err && wr_ovf_err, "R8/R9 flags sticky", {wr_ovf_err, rd_unf_err}, 3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule